// File: doc/BRIEF.md
# Multi-Phase Sampling Time-to-Digital Converter

This block stamps the arrival time of rising edges on a set of pulse inputs. Every input is registered on four copies of one system clock, spaced a quarter period apart (0, 90, 180 and 270 degrees). With a 250 MHz system clock this gives a 1 ns time bin. The four samples are then moved into the 0-degree clock domain and pass through a short synchronizer chain. A decode stage then finds the first quarter-period slot in which the input is high after being low, and turns that slot into a 2-bit fine code.

A free-running coarse counter on the 0-degree clock gives the upper bits of each stamp. For every detected edge, a channel raises its valid strobe for one reference cycle. The stamp presented with that strobe is the coarse count shifted left by two bits, plus the fine code. Channels are built in groups of four, and the channel count is a parameter that must be a multiple of the group size. The four clocks come from outside the block.

Top module: `mps_tdc`

## Requirements
- R1: While `rst` is high, and at the first sampling point after it falls, every `stamp_valid` bit is 0 and every `stamp` field is 0.
- R2: A sampling window starts at a 0-degree clock edge and covers four samples, taken at that edge and 1, 2 and 3 quarter periods later (sample indices 0 to 3). The fine code, `stamp` bits [1:0] of a channel's field, is the index of the sample at which a rising edge is seen.
- R3: Each channel field is COARSE_W+2 bits. Bits [COARSE_W+1:2] hold the window number k. Window 0 starts at the first 0-degree edge at which `rst` is sampled low, and the number rises by one per reference cycle.
- R4: The strobe for an edge in window k is high in the reference cycle that follows the (k+SYNC_STAGES+1)-th 0-degree edge. With the default parameters this is 3 edges after the window starts.
- R5: Only low-to-high changes are stamped. Falling edges, and inputs that stay high or stay low, raise no strobe.
- R6: If one window holds more than one rising edge, only the one with the lowest sample index is reported.
- R7: Each detected edge raises `stamp_valid` for exactly one reference cycle. Edges in consecutive windows give strobes in consecutive cycles. `stamp` keeps its value while the strobe is low.
- R8: Channels are independent. Edges arriving at once on all channels each give a stamp on that channel's own slice, `stamp[ch*(COARSE_W+2) +: COARSE_W+2]`.
- R9: The coarse count wraps modulo 2^COARSE_W with no indication.
- R10: A rise between sample 3 of one window and sample 0 of the next is reported with fine code 0 in the later window. The decode compares sample 0 with the previous window's sample 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_q0 | input | 1 | Reference clock, 0-degree phase |
| clk_q1 | input | 1 | Same clock shifted by a quarter period |
| clk_q2 | input | 1 | Same clock shifted by half a period |
| clk_q3 | input | 1 | Same clock shifted by three quarter periods |
| rst | input | 1 | Synchronous active-high reset (0-degree domain) |
| pulse_in | input | NCH | Asynchronous pulse inputs, one per channel |
| stamp_valid | output | NCH | One-cycle strobe per detected rising edge |
| stamp | output | NCH*(COARSE_W+2) | Per-channel timestamp, coarse count above a 2-bit fine code |

## Verification
The phase capture and decode have no state visible from outside, so faults must show up as wrong stamps or wrong strobes.
- A wrongly ordered or mis-indexed phase sample shows as a fine code off by one or more bins on the very strobe of the affected edge.
- A missing or stale previous-window bit shows as a spurious or lost fine-0 strobe in the window after an edge.
- A synchronizer chain of the wrong depth, or a coarse tag computed with the wrong offset, moves the strobe or its coarse field by whole cycles. Every stamp is therefore compared against its window number and its due cycle.
- A counter fault appears in the coarse field of the next stamp, and at the latest at the modulo wrap.

// File: rtl/mps_tdc_pkg.sv
package mps_tdc_pkg;
  localparam int NPHASE = 4;
  localparam int FINE_W = 2;

  typedef logic [NPHASE-1:0] phase_word_t;

  typedef struct packed {
    logic              hit;
    logic [FINE_W-1:0] idx;
  } rise_info_t;

  // ext[0] is the last sample of the previous window, ext[i+1] is sample i.
  // Scanning from the top down lets the lowest index overwrite later ones.
  function automatic rise_info_t find_first_rise(input logic [NPHASE:0] ext);
    rise_info_t r;
    r = '0;
    for (int i = NPHASE - 1; i >= 0; i--) begin
      if (ext[i+1] && !ext[i]) begin
        r.hit = 1'b1;
        r.idx = FINE_W'(i);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/mps_coarse_counter.sv
module mps_coarse_counter #(
  parameter int COARSE_W = 30,
  parameter int LAT      = 3
) (
  input  logic                clk,
  input  logic                rst,
  output logic [COARSE_W-1:0] tag
);
  logic [COARSE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  // The decode register sees window k when the count already reads k+LAT.
  assign tag = cnt - COARSE_W'(LAT);

  // R9
  coarse_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt == COARSE_W'($past(cnt) + 1'b1));
endmodule

// File: rtl/mps_phase_capture.sv
module mps_phase_capture
  import mps_tdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic [NPHASE-1:0] clk_ph,
  input  logic              rst,
  input  logic              din,
  output phase_word_t       word
);
  phase_word_t smp;
  phase_word_t chain [SYNC_STAGES];

  // First flop of each sample lives in its own phase domain.
  for (genvar p = 0; p < NPHASE; p++) begin : g_ph
    logic smp_q;
    always_ff @(posedge clk_ph[p]) begin
      if (rst) smp_q <= 1'b0;
      else     smp_q <= din;
    end
    assign smp[p] = smp_q;
  end

  // Re-time all four samples onto the 0-degree clock, then extra stages.
  always_ff @(posedge clk_ph[0]) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= smp;
      for (int s = 1; s < SYNC_STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign word = chain[SYNC_STAGES-1];
endmodule

// File: rtl/mps_edge_encode.sv
module mps_edge_encode
  import mps_tdc_pkg::*;
#(
  parameter int COARSE_W = 30,
  localparam int TSW     = COARSE_W + FINE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  phase_word_t         word,
  input  logic [COARSE_W-1:0] tag,
  output logic                valid,
  output logic [TSW-1:0]      ts
);
  logic            prev_last;
  logic [NPHASE:0] ext;
  rise_info_t      info;

  assign ext  = {word, prev_last};
  assign info = find_first_rise(ext);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_last <= 1'b0;
      valid     <= 1'b0;
      ts        <= '0;
    end else begin
      prev_last <= word[NPHASE-1];
      valid     <= info.hit;
      if (info.hit) ts <= {tag, info.idx};
    end
  end

  // R2
  edge_shape_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> ((($past(ext) >> ts[FINE_W-1:0]) & 5'b00011) == 5'b00010));

  // R6
  earliest_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && ts[FINE_W-1:0] != '0) |-> !($past(ext[1]) && !$past(ext[0])));

  // R5
  hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    (&ext) |=> !valid);

  // R7
  hold_ts_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |-> $stable(ts));
endmodule

// File: rtl/mps_tdc_group.sv
module mps_tdc_group
  import mps_tdc_pkg::*;
#(
  parameter int GRP         = 4,
  parameter int COARSE_W    = 30,
  parameter int SYNC_STAGES = 2,
  localparam int TSW        = COARSE_W + FINE_W
) (
  input  logic [NPHASE-1:0]  clk_ph,
  input  logic               rst,
  input  logic [GRP-1:0]     din,
  input  logic [COARSE_W-1:0] tag,
  output logic [GRP-1:0]     valid,
  output logic [GRP*TSW-1:0] ts
);
  for (genvar c = 0; c < GRP; c++) begin : g_ch
    phase_word_t word;

    mps_phase_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk_ph (clk_ph),
      .rst    (rst),
      .din    (din[c]),
      .word   (word)
    );

    mps_edge_encode #(.COARSE_W(COARSE_W)) u_enc (
      .clk   (clk_ph[0]),
      .rst   (rst),
      .word  (word),
      .tag   (tag),
      .valid (valid[c]),
      .ts    (ts[c*TSW +: TSW])
    );
  end
endmodule

// File: rtl/mps_tdc.sv
module mps_tdc
  import mps_tdc_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int CH_PER_GRP  = 4,
  parameter int COARSE_W    = 30,
  parameter int SYNC_STAGES = 2,
  localparam int TSW        = COARSE_W + FINE_W,
  localparam int NGRP       = NCH / CH_PER_GRP,
  localparam int LAT        = SYNC_STAGES + 1
) (
  input  logic               clk_q0,
  input  logic               clk_q1,
  input  logic               clk_q2,
  input  logic               clk_q3,
  input  logic               rst,
  input  logic [NCH-1:0]     pulse_in,
  output logic [NCH-1:0]     stamp_valid,
  output logic [NCH*TSW-1:0] stamp
);
  logic [NPHASE-1:0]   clk_ph;
  logic [COARSE_W-1:0] tag;

  assign clk_ph = {clk_q3, clk_q2, clk_q1, clk_q0};

  mps_coarse_counter #(.COARSE_W(COARSE_W), .LAT(LAT)) u_cnt (
    .clk (clk_q0),
    .rst (rst),
    .tag (tag)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    mps_tdc_group #(
      .GRP         (CH_PER_GRP),
      .COARSE_W    (COARSE_W),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_grp (
      .clk_ph (clk_ph),
      .rst    (rst),
      .din    (pulse_in[g*CH_PER_GRP +: CH_PER_GRP]),
      .tag    (tag),
      .valid  (stamp_valid[g*CH_PER_GRP +: CH_PER_GRP]),
      .ts     (stamp[g*CH_PER_GRP*TSW +: CH_PER_GRP*TSW])
    );
  end
endmodule

// File: tb/mps_tdc_bench.sv
`timescale 1ns/100ps
module mps_tdc_bench;
  localparam int NCH = 8;
  localparam int CW  = 6;
  localparam int TSW = CW + 2;
  localparam int SYN = 2;
  localparam int LAT = SYN + 1;

  logic clk0 = 0, clk1 = 0, clk2 = 0, clk3 = 0;
  logic rst = 1'b1;
  logic [NCH-1:0]     pin = '0;
  logic [NCH-1:0]     stamp_valid;
  logic [NCH*TSW-1:0] stamp;

  initial forever #2 clk0 = ~clk0;
  initial begin #1; forever #2 clk1 = ~clk1; end
  initial begin #2; forever #2 clk2 = ~clk2; end
  initial begin #3; forever #2 clk3 = ~clk3; end

  mps_tdc #(.NCH(NCH), .CH_PER_GRP(4), .COARSE_W(CW), .SYNC_STAGES(SYN)) u_mps_tdc (
    .clk_q0(clk0), .clk_q1(clk1), .clk_q2(clk2), .clk_q3(clk3),
    .rst(rst), .pulse_in(pin), .stamp_valid(stamp_valid), .stamp(stamp)
  );

  typedef struct { int due; logic [TSW-1:0] ts; } exp_t;
  exp_t exp_q [NCH][$];

  int bc = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always @(posedge clk0) bc <= rst ? 0 : bc + 1;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Scoreboard monitor: sampled away from the 0-degree edge.
  always @(negedge clk0) begin
    if (!rst) begin
      for (int ch = 0; ch < NCH; ch++) begin
        logic [TSW-1:0] got;
        got = stamp[ch*TSW +: TSW];
        if (exp_q[ch].size() != 0 && exp_q[ch][0].due < bc) begin
          exp_t e;
          e = exp_q[ch].pop_front();
          n_chk++; n_bad++;
          $display("FAIL R4 ch%0d missing strobe: actual none at cycle %0d expected ts %0d due %0d",
                   ch, bc, e.ts, e.due);
        end
        if (stamp_valid[ch]) begin
          n_chk++;
          if (exp_q[ch].size() == 0) begin
            n_bad++;
            $display("FAIL R5/R7 ch%0d unexpected strobe: actual ts %0d expected none", ch, got);
          end else begin
            exp_t e;
            e = exp_q[ch].pop_front();
            if (e.due != bc || e.ts != got) begin
              n_bad++;
              $display("FAIL R2/R3/R4 ch%0d: actual ts %0d cycle %0d expected ts %0d cycle %0d",
                       ch, got, bc, e.ts, e.due);
            end
          end
        end
      end
    end
  end

  task automatic sync_window(output int k);
    @(posedge clk0);
    #0.1;
    k = bc;
  endtask

  task automatic expect_edge(input int ch, input int k, input int fine);
    exp_t e;
    e.due = k + LAT + 1;
    e.ts  = TSW'(((k % (1 << CW)) << 2) + fine);
    exp_q[ch].push_back(e);
  endtask

  // Rising edge lands just before sample `fine` of the next window.
  task automatic pulse(input int ch, input int fine, input int width_ns);
    int k;
    sync_window(k);
    expect_edge(ch, k, fine);
    #(3.4 + fine);
    pin[ch] = 1'b1;
    #(width_ns);
    pin[ch] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk0);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL R4 watchdog: actual still running expected finished");
    finish_run();
  end

  initial begin
    int k;
    // R1: reset state
    repeat (3) @(negedge clk0);
    n_chk++;
    if (stamp_valid !== '0 || stamp !== '0) begin
      n_bad++;
      $display("FAIL R1 reset: actual valid %0h stamp %0h expected 0 0", stamp_valid, stamp);
    end
    @(posedge clk0); #0.5; rst = 1'b0;
    @(negedge clk0);
    n_chk++;
    if (stamp_valid !== '0 || stamp !== '0) begin
      n_bad++;
      $display("FAIL R1 after release: actual valid %0h stamp %0h expected 0 0", stamp_valid, stamp);
    end
    idle(4);

    // R2, R10: every fine bin on one channel (fine 0 crosses the window boundary)
    for (int f = 0; f < 4; f++) begin
      pulse(0, f, 2);
      idle(3);
    end

    // R8: all channels at once with distinct fine codes
    fork
      pulse(0, 0, 2); pulse(1, 1, 2); pulse(2, 2, 2); pulse(3, 3, 2);
      pulse(4, 3, 2); pulse(5, 2, 2); pulse(6, 1, 2); pulse(7, 0, 2);
    join
    idle(6);

    // R6: two rises in one window (samples 0 and 2 high, 1 low)
    sync_window(k);
    expect_edge(1, k, 0);
    #3.4; pin[1] = 1'b1;
    #1;   pin[1] = 1'b0;
    #1;   pin[1] = 1'b1;
    #3;   pin[1] = 1'b0;
    idle(6);

    // R5: long high level, single strobe, falling edge ignored
    pulse(2, 1, 40);
    idle(10);

    // R7, R10: rise at sample 2, low at sample 3, rise again before next sample 0
    sync_window(k);
    expect_edge(3, k, 2);
    expect_edge(3, k + 1, 0);
    #5.4; pin[3] = 1'b1;
    #1;   pin[3] = 1'b0;
    #1;   pin[3] = 1'b1;
    #2;   pin[3] = 1'b0;
    idle(6);

    // R9: run past the coarse wrap with a pulse train
    for (int i = 0; i < 40; i++) begin
      pulse(4, i % 4, 2);
      idle(1);
    end
    idle(10);

    // R4/R7: nothing left undelivered
    for (int ch = 0; ch < NCH; ch++) begin
      n_chk++;
      if (exp_q[ch].size() != 0) begin
        n_bad++;
        $display("FAIL R4 ch%0d: actual %0d pending expected 0", ch, exp_q[ch].size());
      end
    end
    finish_run();
  end
endmodule